// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a chain of small synchronous binary up-counter stages that together behave as one wide counter. Each stage holds a few bits (four by default), all clocked on the same rising edge. A stage can be cleared at once by an active-low clear that needs no clock. It can be preset from a data word by an active-low load that acts on the next edge. It counts up by one only when both of its count enables are high. A combinational carry output lets the next stage know when this stage is about to roll over.

The wrapper chains `N_STAGES` stages. One shared enable drives the P enable of every stage, and a chain-entry enable drives the T enable of the first stage. Each later stage's T enable is the carry of the stages below it. A generate option picks how that T enable is formed: as a serial chain through each stage's carry, or as a parallel look-ahead term computed from all lower bits. Both forms give the same behaviour. The carry of the last stage is brought out as a terminal-count flag, so wrappers can themselves be cascaded.

Top module: `casc_cnt_chain`

## Requirements
- R1: While `clr_n` is low the whole count is 0, and it becomes 0 as soon as `clr_n` falls, without a clock edge and whatever the levels of load and the enables.
- R2: With `clr_n` high and `load_n` low, the next rising edge copies `load_data_i` into `count_o`, whatever the enable levels.
- R3: With `clr_n` and `load_n` high and both `cnt_en_p` and `cnt_en_t` high, each rising edge adds one to `count_o`, which is treated as a single unsigned value.
- R4: With `clr_n` and `load_n` high, `count_o` holds its value when `cnt_en_p` is low, and also when `cnt_en_t` is low.
- R5: An increment from all ones gives all zeros.
- R6: `stage_carry_o[k]` is high exactly when stage k's T enable is high and stage k's bits (`count_o[k*STAGE_W +: STAGE_W]`) are all ones. Stage 0's T enable is `cnt_en_t`, and stage k's T enable is `stage_carry_o[k-1]`.
- R7: `term_cnt_o` is high exactly when every bit of `count_o` is 1 and `cnt_en_t` is high. It does not depend on `cnt_en_p`.
- R8: Changes on the enables between clock edges have no effect. Only their levels at the rising edge decide the next count.
- R9: On an increment across a stage boundary (for example 0x0FF to 0x100), every affected stage changes on the same edge.
- R10: The serial-carry variant (`LOOKAHEAD=0`) and the look-ahead variant (`LOOKAHEAD=1`) give identical outputs for identical inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for every stage |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_p | input | 1 | Shared count enable, fed to every stage's P enable |
| cnt_en_t | input | 1 | Chain-entry count enable, fed to stage 0's T enable |
| load_data_i | input | STAGE_W*N_STAGES | Preset value |
| count_o | output | STAGE_W*N_STAGES | Current count, stage 0 in the low bits |
| stage_carry_o | output | N_STAGES | Carry output of each stage |
| term_cnt_o | output | 1 | Terminal count, equal to the last stage's carry |

## Verification
On every cycle, assertions inside the stages check the load, increment, hold and clear rules, and check that each carry only rises when its stage is all ones. At the wrapper level they check that a chain-wide increment adds exactly one to the whole value and that the terminal flag implies an all-ones count. Only the bench's scenarios can show the following. The clear acts in the middle of a cycle, before any edge. Enable pulses that come and go between edges leave the count alone. The two carry variants agree. The preset-to-twelve sequence wraps through zero and then stops when counting is inhibited.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;

   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_INC  = 2'd1,
      CNT_LOAD = 2'd2
   } cnt_op_e;

   // Load wins over both enables; counting needs both enables.
   function automatic cnt_op_e pick_op(input logic load_n,
                                       input logic en_p,
                                       input logic en_t);
      cnt_op_e op;
      if (!load_n)            op = CNT_LOAD;
      else if (en_p && en_t)  op = CNT_INC;
      else                    op = CNT_HOLD;
      return op;
   endfunction

endpackage

// File: rtl/casc_cnt_next.sv
module casc_cnt_next
   import casc_cnt_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         load_n,
   input  logic         en_p,
   input  logic         en_t,
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] cur_i,
   output logic [W-1:0] nxt_o
);

   localparam logic [W-1:0] ONE = W'(1);

   cnt_op_e op;

   always_comb begin
      op = pick_op(load_n, en_p, en_t);
      unique case (op)
         CNT_LOAD: nxt_o = data_i;
         CNT_INC:  nxt_o = cur_i + ONE;
         default:  nxt_o = cur_i;
      endcase
   end

endmodule

// File: rtl/casc_cnt_stage.sv
module casc_cnt_stage #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr_n,
   input  logic         load_n,
   input  logic         en_p,
   input  logic         en_t,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] cnt_o,
   output logic         carry_o
);

   localparam logic [W-1:0] ALL_ONES = '1;

   if (W < 1) begin : g_bad_w
      $error("casc_cnt_stage: W must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;

   casc_cnt_next #(.W(W)) u_next (
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (en_t),
      .data_i (data_i),
      .cur_i  (cnt_q),
      .nxt_o  (cnt_d)
   );

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o   = cnt_q;
   assign carry_o = en_t & (cnt_q == ALL_ONES);

   // R1: held at zero while clear is low
   assert_clear_zero_R1: assert property (@(posedge clk)
      !clr_n |-> (cnt_o == '0));

   // R2: load copies the data word
   assert_load_copy_R2: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> (cnt_o == $past(data_i)));

   // R3: count by one (wrapping, R5) when both enables are high
   assert_count_step_R3: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && en_p && en_t) |=> (cnt_o == W'($past(cnt_o) + W'(1))));

   // R4: hold when either enable is low
   assert_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !(en_p && en_t)) |=> $stable(cnt_o));

   // R6: carry only with T high and the stage full
   assert_carry_full_R6: assert property (@(posedge clk) disable iff (!clr_n)
      carry_o |-> (en_t && (cnt_o == ALL_ONES)));

endmodule

// File: rtl/casc_cnt_chain.sv
module casc_cnt_chain #(
   parameter int STAGE_W   = 4,
   parameter int N_STAGES  = 3,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic                          clk,
   input  logic                          clr_n,
   input  logic                          load_n,
   input  logic                          cnt_en_p,
   input  logic                          cnt_en_t,
   input  logic [STAGE_W*N_STAGES-1:0]   load_data_i,
   output logic [STAGE_W*N_STAGES-1:0]   count_o,
   output logic [N_STAGES-1:0]           stage_carry_o,
   output logic                          term_cnt_o
);

   localparam int TOTAL_W = STAGE_W * N_STAGES;
   localparam logic [TOTAL_W-1:0] FULL = '1;

   if (STAGE_W < 1) begin : g_bad_sw
      $error("casc_cnt_chain: STAGE_W must be at least 1");
   end
   if (N_STAGES < 1) begin : g_bad_ns
      $error("casc_cnt_chain: N_STAGES must be at least 1");
   end

   for (genvar k = 0; k < N_STAGES; k++) begin : g_st
      logic               t_en;
      logic               car;
      logic [STAGE_W-1:0] q;

      if (k == 0) begin : g_first
         assign t_en = cnt_en_t;
      end else if (LOOKAHEAD) begin : g_look
         // parallel term over all lower bits
         assign t_en = cnt_en_t & (&count_o[k*STAGE_W-1:0]);
      end else begin : g_serial
         assign t_en = g_st[k-1].car;
      end

      casc_cnt_stage #(.W(STAGE_W)) u_stage (
         .clk     (clk),
         .clr_n   (clr_n),
         .load_n  (load_n),
         .en_p    (cnt_en_p),
         .en_t    (t_en),
         .data_i  (load_data_i[k*STAGE_W +: STAGE_W]),
         .cnt_o   (q),
         .carry_o (car)
      );

      assign count_o[k*STAGE_W +: STAGE_W] = q;
      assign stage_carry_o[k]              = car;
   end

   assign term_cnt_o = g_st[N_STAGES-1].car;

   // R3 and R9: the chain steps as one value, all stages on one edge
   assert_chain_step_R3: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && cnt_en_p && cnt_en_t) |=>
         (count_o == TOTAL_W'($past(count_o) + TOTAL_W'(1))));

   // R7: terminal flag means full count with the entry enable high
   assert_term_full_R7: assert property (@(posedge clk) disable iff (!clr_n)
      term_cnt_o |-> (cnt_en_t && (count_o == FULL)));

   // R1: whole chain at zero while clear is low
   assert_chain_clear_R1: assert property (@(posedge clk)
      !clr_n |-> (count_o == '0));

endmodule

// File: tb/casc_cnt_chain_tb.sv
`timescale 1ns/1ps
module casc_cnt_chain_tb;

   localparam int SW = 4;
   localparam int NS = 3;
   localparam int TW = SW * NS;
   localparam int MASK  = (1 << TW) - 1;
   localparam int SMASK = (1 << SW) - 1;

   logic          clk = 1'b0;
   logic          clr_n = 1'b0;
   logic          load_n = 1'b1;
   logic          en_p = 1'b0;
   logic          en_t = 1'b0;
   logic [TW-1:0] din = '0;

   logic [TW-1:0] cnt_a, cnt_b;
   logic [NS-1:0] car_a, car_b;
   logic          tc_a, tc_b;

   int total = 0;
   int bad   = 0;
   int m     = 0;

   always #2.5 clk = ~clk;

   casc_cnt_chain #(.STAGE_W(SW), .N_STAGES(NS), .LOOKAHEAD(1'b1)) u_dut (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_p(en_p),
      .cnt_en_t(en_t), .load_data_i(din), .count_o(cnt_a),
      .stage_carry_o(car_a), .term_cnt_o(tc_a));

   casc_cnt_chain #(.STAGE_W(SW), .N_STAGES(NS), .LOOKAHEAD(1'b0)) u_rip (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_p(en_p),
      .cnt_en_t(en_t), .load_data_i(din), .count_o(cnt_b),
      .stage_carry_o(car_b), .term_cnt_o(tc_b));

   function automatic logic [NS-1:0] exp_carry(input int v, input logic t0);
      logic [NS-1:0] c;
      logic t;
      t = t0;
      for (int k = 0; k < NS; k++) begin
         c[k] = t && (((v >> (k*SW)) & SMASK) == SMASK);
         t = c[k];
      end
      return c;
   endfunction

   task automatic chk(input string req);
      logic [NS-1:0] ec;
      logic          et;
      ec = exp_carry(m, en_t);
      et = ec[NS-1];
      total++;
      if (cnt_a !== TW'(m) || car_a !== ec || tc_a !== et) begin
         bad++;
         $display("FAIL %s: look-ahead count=%h carry=%b tc=%b expected count=%h carry=%b tc=%b",
                  req, cnt_a, car_a, tc_a, TW'(m), ec, et);
      end else if (cnt_b !== TW'(m) || car_b !== ec || tc_b !== et) begin
         bad++;
         $display("FAIL %s (R10 serial): count=%h carry=%b tc=%b expected count=%h carry=%b tc=%b",
                  req, cnt_b, car_b, tc_b, TW'(m), ec, et);
      end
   endtask

   // model update uses the input levels at the edge
   task automatic tick(input string req);
      @(posedge clk);
      if (!clr_n)                m = 0;
      else if (!load_n)          m = int'(din);
      else if (en_p && en_t)     m = (m + 1) & MASK;
      #1;
      chk(req);
   endtask

   initial begin
      #1_000_000;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // reset state
      #1;
      chk("R1 reset");
      tick("R1 held");
      clr_n = 1'b1;
      tick("R4 idle after clear");

      // preset twelve in the low stage, enables low
      load_n = 1'b0; din = TW'('hFFC);
      tick("R2 load with enables low");
      load_n = 1'b1;
      en_p = 1'b1; en_t = 1'b1;
      #0.5 chk("R7 not full");
      for (int i = 0; i < 6; i++) tick("R3 R5 R6 R7 count sequence");
      en_p = 1'b0;
      tick("R4 inhibit");
      tick("R4 inhibit");

      // terminal flag ignores P, follows T
      load_n = 1'b0; din = '1;
      tick("R2 load all ones");
      load_n = 1'b1; en_p = 1'b0; en_t = 1'b1;
      #0.5 chk("R7 tc high with P low");
      tick("R4 hold with P low");
      en_p = 1'b1; en_t = 1'b0;
      #0.5 chk("R7 tc low with T low");
      tick("R4 hold with T low");

      // enable pulse between edges
      en_p = 1'b1; en_t = 1'b1;
      #1 en_p = 1'b0;
      tick("R8 mid-cycle pulse ignored");
      en_t = 1'b0; en_p = 1'b1;
      #1 en_t = 1'b1;
      #1 en_t = 1'b0;
      tick("R8 T pulse ignored");

      // cross stage boundaries
      load_n = 1'b0; din = TW'('h0FF);
      tick("R2 load 0FF");
      load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
      tick("R9 0FF to 100");
      load_n = 1'b0; din = TW'('h00F);
      tick("R2 load 00F");
      load_n = 1'b1;
      tick("R9 00F to 010");

      // clear in mid-cycle with load active and enables high
      load_n = 1'b0; din = TW'('hABC);
      #0.7 clr_n = 1'b0;
      m = 0;
      #0.5 chk("R1 async clear mid-cycle");
      tick("R1 clear beats load");
      #1 clr_n = 1'b1;
      tick("R2 load after clear");
      load_n = 1'b1;

      // mixed stimulus
      for (int i = 0; i < 400; i++) begin
         en_p   = ($urandom % 8) != 0;
         en_t   = ($urandom % 8) != 0;
         load_n = ($urandom % 16) != 0;
         din    = TW'($urandom);
         if (($urandom % 64) == 0) clr_n = 1'b0;
         else                      clr_n = 1'b1;
         if (!clr_n) begin
            m = 0;
            #0.5 chk("R1 random clear");
         end
         tick("R2 R3 R4 R6 R10 mixed");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule